// File: doc/BRIEF.md
# Tokenized Two-Phase Stream Link

This block joins two processing elements with a point-to-point link. Each transfer moves a 16-bit data word plus a 2-bit token. The token tells the consumer what kind of structure the word belongs to. The sender half takes a word from its local producer. It flips its request line once and holds the word steady on the link. It then refuses further words until the acknowledge line has caught up. The receiver half detects the request transition and captures the word. It then raises a local enable, so the consuming module only works while data is present. When the consumer reports the word done, it flips the acknowledge line once.

Signalling is two-phase: every transition of request or acknowledge is one event, and there is no return-to-zero phase. Both halves run on one clock. Each crossing line passes through a two-stage synchronizer, so producer and consumer may accept and retire words at unrelated, changing rates. An active-low reset acts as the network reset. It drops both handshake lines to 0 and throws away any word in flight.

Top module: `stream_link`

## Requirements
- R1: After reset, link_req_o and link_ack_o are 0, dst_en_o is 0 and src_ready_o is 1.
- R2: Every word accepted from the producer (src_valid_i and src_ready_o high at a clock edge) reaches the consumer exactly once, in acceptance order, with its 16-bit data unchanged.
- R3: The token travels unchanged with its word. The encoding is 2'b00 for a regular element, 2'b01 for the last element of a vector, 2'b10 for the last element of a matrix and 2'b11 for a scalar. dst_eov_o is 1 exactly while dst_en_o is 1 and the held token is 2'b01.
- R4: link_req_o changes level exactly once for each accepted word and holds its level in every other cycle.
- R5: While link_req_o differs from link_ack_o, src_ready_o is 0.
- R6: dst_en_o rises only while link_req_o differs from link_ack_o, that is, only after a new request event that has not yet been answered.
- R7: link_ack_o changes level exactly once for each cycle in which dst_done_i and dst_en_o are both 1, and holds its level otherwise.
- R8: dst_done_i while dst_en_o is 0 has no effect: link_ack_o does not change.
- R9: src_valid_i while src_ready_o is 0 is ignored: link_req_o does not change and the offered word is never delivered.
- R10: While dst_en_o is 1 and dst_done_i is 0, dst_en_o stays 1 and dst_data_o and dst_tok_o stay stable.
- R11: Reset during a transfer discards the pending word. The word is never delivered, and words sent after reset arrive normally.
- R12: A consumer that stalls for several cycles per word loses and duplicates nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Common clock |
| rst_ni | input | 1 | Active-low asynchronous network reset |
| src_valid_i | input | 1 | Producer offers a word |
| src_data_i | input | 16 | Producer data word |
| src_tok_i | input | 2 | Producer token |
| src_ready_o | output | 1 | Link idle, word will be taken |
| dst_en_o | output | 1 | Consumer enable: a word is held |
| dst_data_o | output | 16 | Held data word |
| dst_tok_o | output | 2 | Held token |
| dst_eov_o | output | 1 | Held word closes a vector |
| dst_done_i | input | 1 | Consumer has used the held word |
| link_req_o | output | 1 | Request line level |
| link_ack_o | output | 1 | Acknowledge line level |

## Verification
The properties assume the producer and consumer obey the local handshake. The producer's offer only counts when src_ready_o is high. A done pulse only means something while dst_en_o is high. The stimulus breaks both rules on purpose, so that the properties and the checks show the offending strobes leave the handshake lines untouched. Otherwise the producer drives its inputs only at falling edges and waits for src_ready_o. The consumer pulses dst_done_i for one cycle after a chosen stall, which keeps every transfer within the assumed protocol.

// File: rtl/stream_link_pkg.sv
package stream_link_pkg;
  localparam int unsigned TOK_W = 2;

  typedef enum logic [TOK_W-1:0] {
    TOK_ELEM   = 2'b00,
    TOK_VEND   = 2'b01,
    TOK_MEND   = 2'b10,
    TOK_SCALAR = 2'b11
  } tok_e;
endpackage

// File: rtl/link_sync.sv
module link_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[g] <= 1'b0;
        else         chain_q[g] <= d_i;
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[g] <= 1'b0;
        else         chain_q[g] <= chain_q[g-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/link_tx.sv
module link_tx #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned TOK_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [TOK_W-1:0]  tok_i,
  output logic              ready_o,
  input  logic              ack_sync_i,
  output logic              req_o,
  output logic [DATA_W-1:0] data_o,
  output logic [TOK_W-1:0]  tok_o
);
  logic              req_q;
  logic [DATA_W-1:0] data_q;
  logic [TOK_W-1:0]  tok_q;
  logic              take;

  // busy while the last event is unanswered
  assign ready_o = (req_q == ack_sync_i);
  assign take    = valid_i && ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      data_q <= '0;
      tok_q  <= '0;
    end else if (take) begin
      req_q  <= ~req_q;
      data_q <= data_i;
      tok_q  <= tok_i;
    end
  end

  assign req_o  = req_q;
  assign data_o = data_q;
  assign tok_o  = tok_q;
endmodule

// File: rtl/link_rx.sv
module link_rx #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned TOK_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_sync_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [TOK_W-1:0]  tok_i,
  output logic              en_o,
  output logic [DATA_W-1:0] data_o,
  output logic [TOK_W-1:0]  tok_o,
  input  logic              done_i,
  output logic              ack_o
);
  logic              seen_q;
  logic              full_q;
  logic              ack_q;
  logic [DATA_W-1:0] data_q;
  logic [TOK_W-1:0]  tok_q;
  logic              event_in;
  logic              retire;

  assign event_in = (req_sync_i != seen_q) && !full_q;
  assign retire   = full_q && done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      full_q <= 1'b0;
      ack_q  <= 1'b0;
      data_q <= '0;
      tok_q  <= '0;
    end else begin
      if (event_in) begin
        seen_q <= req_sync_i;
        full_q <= 1'b1;
        data_q <= data_i;   // bundled data is stable since the request event
        tok_q  <= tok_i;
      end else if (retire) begin
        full_q <= 1'b0;
        ack_q  <= ~ack_q;
      end
    end
  end

  assign en_o   = full_q;
  assign data_o = data_q;
  assign tok_o  = tok_q;
  assign ack_o  = ack_q;
endmodule

// File: rtl/stream_link.sv
module stream_link
  import stream_link_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              src_valid_i,
  input  logic [DATA_W-1:0] src_data_i,
  input  logic [TOK_W-1:0]  src_tok_i,
  output logic              src_ready_o,
  output logic              dst_en_o,
  output logic [DATA_W-1:0] dst_data_o,
  output logic [TOK_W-1:0]  dst_tok_o,
  output logic              dst_eov_o,
  input  logic              dst_done_i,
  output logic              link_req_o,
  output logic              link_ack_o
);
  logic              req_w, ack_w, req_s, ack_s;
  logic [DATA_W-1:0] bus_data;
  logic [TOK_W-1:0]  bus_tok;

  link_tx #(.DATA_W(DATA_W), .TOK_W(TOK_W)) tx_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .valid_i(src_valid_i), .data_i(src_data_i), .tok_i(src_tok_i),
    .ready_o(src_ready_o), .ack_sync_i(ack_s),
    .req_o(req_w), .data_o(bus_data), .tok_o(bus_tok)
  );

  link_sync #(.STAGES(SYNC_STAGES)) req_sync_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(req_w), .q_o(req_s)
  );

  link_sync #(.STAGES(SYNC_STAGES)) ack_sync_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ack_w), .q_o(ack_s)
  );

  link_rx #(.DATA_W(DATA_W), .TOK_W(TOK_W)) rx_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_sync_i(req_s), .data_i(bus_data), .tok_i(bus_tok),
    .en_o(dst_en_o), .data_o(dst_data_o), .tok_o(dst_tok_o),
    .done_i(dst_done_i), .ack_o(ack_w)
  );

  assign dst_eov_o  = dst_en_o && (tok_e'(dst_tok_o) == TOK_VEND);
  assign link_req_o = req_w;
  assign link_ack_o = ack_w;
endmodule

// File: rtl/stream_link_chk.sv
module stream_link_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned TOK_W  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              src_valid_i,
  input logic              src_ready_o,
  input logic              dst_en_o,
  input logic [DATA_W-1:0] dst_data_o,
  input logic [TOK_W-1:0]  dst_tok_o,
  input logic              dst_done_i,
  input logic              link_req_o,
  input logic              link_ack_o
);
  a_r4_req_flips: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_valid_i && src_ready_o) |=> (link_req_o != $past(link_req_o)));

  a_r9_req_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(src_valid_i && src_ready_o) |=> $stable(link_req_o));

  a_r5_busy_stalls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_req_o != link_ack_o) |-> !src_ready_o);

  a_r6_en_after_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dst_en_o) |-> (link_req_o != link_ack_o));

  a_r7_ack_flips: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dst_done_i && dst_en_o) |=> (link_ack_o != $past(link_ack_o)));

  a_r8_ack_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dst_done_i && dst_en_o) |=> $stable(link_ack_o));

  a_r10_hold_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dst_en_o && !dst_done_i) |=> (dst_en_o && $stable(dst_data_o) && $stable(dst_tok_o)));
endmodule

bind stream_link stream_link_chk #(.DATA_W(DATA_W), .TOK_W(2)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .src_valid_i(src_valid_i),
  .src_ready_o(src_ready_o), .dst_en_o(dst_en_o), .dst_data_o(dst_data_o),
  .dst_tok_o(dst_tok_o), .dst_done_i(dst_done_i),
  .link_req_o(link_req_o), .link_ack_o(link_ack_o)
);

// File: tb/stream_link_tb_top.sv
module stream_link_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        src_valid_i = 1'b0;
  logic [15:0] src_data_i = '0;
  logic [1:0]  src_tok_i = '0;
  logic        src_ready_o;
  logic        dst_en_o;
  logic [15:0] dst_data_o;
  logic [1:0]  dst_tok_o;
  logic        dst_eov_o;
  logic        done_c = 1'b0;
  logic        done_p = 1'b0;
  logic        dst_done_i;
  logic        link_req_o, link_ack_o;

  assign dst_done_i = done_c | done_p;

  always #(CLK_PERIOD/2) clk = ~clk;

  stream_link dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .src_valid_i(src_valid_i), .src_data_i(src_data_i), .src_tok_i(src_tok_i),
    .src_ready_o(src_ready_o), .dst_en_o(dst_en_o), .dst_data_o(dst_data_o),
    .dst_tok_o(dst_tok_o), .dst_eov_o(dst_eov_o), .dst_done_i(dst_done_i),
    .link_req_o(link_req_o), .link_ack_o(link_ack_o)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [17:0] exp_q[$];
  bit cons_on = 0;
  int stall = 0;
  int sent = 0, retired = 0, req_tog = 0, ack_tog = 0;
  logic prev_req = 1'b0, prev_ack = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // handshake event monitor (R4, R7)
  always @(negedge clk) begin
    if (link_req_o != prev_req) req_tog++;
    if (link_ack_o != prev_ack) ack_tog++;
    prev_req = link_req_o;
    prev_ack = link_ack_o;
  end

  // watchdog
  initial begin
    repeat (WATCHDOG) @(posedge clk);
    chk(0, "WDOG", "run did not finish", 0, 1);
    summary();
  end

  // consumer: scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (cons_on && dst_en_o && rst_ni) begin
        logic [17:0] e;
        if (exp_q.size() == 0) begin
          chk(0, "R2", "unexpected word", int'(dst_data_o), 0);
        end else begin
          e = exp_q.pop_front();
          chk(dst_data_o == e[15:0], "R2", "data", int'(dst_data_o), int'(e[15:0]));
          chk(dst_tok_o == e[17:16], "R3", "token", int'(dst_tok_o), int'(e[17:16]));
          chk(dst_eov_o == (e[17:16] == 2'b01), "R3", "eov flag",
              int'(dst_eov_o), int'(e[17:16] == 2'b01));
        end
        for (int i = 0; i < stall; i++) begin
          @(negedge clk);
          chk(dst_en_o && dst_data_o == e[15:0], "R10", "held word",
              int'(dst_data_o), int'(e[15:0]));
        end
        done_c = 1'b1;
        @(negedge clk);
        done_c = 1'b0;
        retired++;
      end
    end
  end

  task automatic send(input logic [15:0] d, input logic [1:0] t);
    while (!src_ready_o) @(negedge clk);
    src_valid_i = 1'b1;
    src_data_i  = d;
    src_tok_i   = t;
    exp_q.push_back({t, d});
    sent++;
    @(negedge clk);
    src_valid_i = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while ((exp_q.size() != 0 || dst_en_o || !src_ready_o) && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(exp_q.size() == 0, "R12", "queue drained", exp_q.size(), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    int s0, r0, q0, a0, c0;
    do_reset();
    // R1
    chk(link_req_o == 0, "R1", "req after reset", int'(link_req_o), 0);
    chk(link_ack_o == 0, "R1", "ack after reset", int'(link_ack_o), 0);
    chk(dst_en_o == 0, "R1", "enable after reset", int'(dst_en_o), 0);
    chk(src_ready_o == 1, "R1", "ready after reset", int'(src_ready_o), 1);

    s0 = sent; r0 = retired; q0 = req_tog; a0 = ack_tog;

    // R2/R3: vector ending with end-of-vector token, fast consumer
    cons_on = 1; stall = 0;
    send(16'h1111, 2'b00);
    send(16'h2222, 2'b00);
    send(16'hBEEF, 2'b00);
    send(16'h4444, 2'b01);
    drain();

    // R3/R12: matrix and scalar tokens, slow consumer
    stall = 4;
    send(16'hA001, 2'b00);
    send(16'hA002, 2'b01);
    send(16'hA003, 2'b00);
    send(16'hA004, 2'b10);
    send(16'h7FFF, 2'b11);
    stall = 1;
    send(16'h0000, 2'b11);
    send(16'hFFFF, 2'b01);
    drain();

    // R8: done strobe with nothing held
    cons_on = 0;
    c0 = int'(link_ack_o);
    done_p = 1'b1;
    @(negedge clk);
    done_p = 1'b0;
    @(negedge clk);
    chk(int'(link_ack_o) == c0, "R8", "ack after idle done", int'(link_ack_o), c0);
    chk(dst_en_o == 0, "R8", "enable after idle done", int'(dst_en_o), 0);

    // R5/R9: offer while busy
    send(16'h5A5A, 2'b00);
    chk(src_ready_o == 0, "R5", "ready while event pending", int'(src_ready_o), 0);
    c0 = int'(link_req_o);
    src_valid_i = 1'b1;
    src_data_i  = 16'hDEAD;
    src_tok_i   = 2'b11;
    @(negedge clk);
    src_valid_i = 1'b0;
    chk(int'(link_req_o) == c0, "R9", "req after busy offer", int'(link_req_o), c0);
    cons_on = 1; stall = 2;
    drain();

    // R4/R7: one event per word on each line
    chk(req_tog - q0 == sent - s0, "R4", "request events", req_tog - q0, sent - s0);
    chk(ack_tog - a0 == retired - r0, "R7", "acknowledge events", ack_tog - a0, retired - r0);

    // R11: reset with a word held
    cons_on = 0;
    send(16'hC0DE, 2'b00);
    while (!dst_en_o) @(negedge clk);
    do_reset();
    void'(exp_q.pop_back());
    chk(dst_en_o == 0, "R11", "enable after reset", int'(dst_en_o), 0);
    chk(link_req_o == 0 && link_ack_o == 0, "R11", "lines after reset",
        int'({link_req_o, link_ack_o}), 0);
    chk(src_ready_o == 1, "R11", "ready after reset", int'(src_ready_o), 1);
    cons_on = 1; stall = 0;
    send(16'h3C3C, 2'b10);
    drain();

    summary();
  end
endmodule